// File: doc/BRIEF.md
# Serial Toeplitz Universal Hash

This block computes a universal hash of a short message that arrives one bit at a time. Mathematically the hash is the product, over GF(2), of a 5-row by 9-column Toeplitz matrix with the message vector, with the result word bit-reversed. The matrix is never held in storage. A five-stage linear feedback shift register slides along a 13-bit pseudo-random sequence, and its state at any moment is the matrix column for the message bit now arriving. An accumulator XORs that column in whenever the arriving bit is 1.

A message begins with a start strobe. The strobe reseeds the register and clears the accumulator. The message bits then follow, each qualified by a valid strobe; idle cycles may sit between them. The message ends on its ninth valid bit, or earlier on a valid bit that carries the end flag. A one-cycle done pulse then announces the finished hash, and the hash output keeps its value until the next start.

Top module: `toeplitz_hash`

## Requirements
- R1: After reset, and in the cycle after a start strobe, hash_o is 0 and done_o is 0. Either event also reseeds the column register and clears the accumulator.
- R2: The column sequence follows s(k+5) = s(k+3) XOR s(k), starting from s0..s4 = 0,0,0,1,0, which gives 0001010111011. A 9-bit message whose only 1 is its j-th sent bit (j counted from 0) yields a hash whose bits, MSB first, are s(j), s(j+1), ..., s(j+4).
- R3: hash_o bit (4-t) equals the XOR, over every sent bit j that is 1, of s(j+t). For the message 000010001 (first sent bit on the left) the hash is 10000. The hash of any message is the XOR of the hashes of its one-hot components.
- R4: The column register steps once for every accepted bit, whether the bit is 0 or 1. A 0 bit leaves the accumulator unchanged, so an all-zero message hashes to 0.
- R5: done_o is high for exactly one cycle, in the cycle after the ninth accepted bit. hash_o carries the new value in that same cycle.
- R6: After completion, hash_o holds its value and done_o stays low until the next start, even when further valid bits arrive.
- R7: bit_i has no effect while bit_vld_i is low, so idle cycles between bits do not change the result.
- R8: An accepted bit with last_i high ends the message early. The missing trailing bits count as zeros, and done_o pulses in the next cycle.
- R9: When start_i and bit_vld_i are high in the same cycle, the start wins and the bit is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also seeds the column register |
| start_i | input | 1 | Begin a new message: reseed and clear |
| bit_vld_i | input | 1 | bit_i carries a message bit this cycle |
| bit_i | input | 1 | Message bit, first-sent bit first |
| last_i | input | 1 | Qualified by bit_vld_i; marks the final bit of a short message |
| hash_o | output | 5 | Registered hash, bit-reversed product word |
| done_o | output | 1 | One-cycle pulse when hash_o is updated |

## Verification
Every accepted bit is folded in at the clock edge that takes it. Only the completing bit also passes through the output register, so the hash and the done pulse appear one cycle after the final bit. The bench drives inputs on falling edges and reads the outputs at the next falling edge after the final bit's edge, where it expects done_o high and the modelled hash. One cycle later it expects done_o low with the hash unchanged. Clearing by start is checked one cycle after the strobe. The reference hash is built in the bench directly from the recurrence and the matrix product definition, and is applied to one-hot, all-zero, all-one, directed and random messages, with random idle gaps and early ends.

// File: rtl/toeplitz_pkg.sv
package toeplitz_pkg;
  // Hash width equals the degree of the column polynomial.
  localparam int unsigned HASH_W  = 5;
  // Number of message bits folded into one hash.
  localparam int unsigned MSG_LEN = 9;
  // Feedback mask: the new top stage is the XOR of stages 3 and 0,
  // which realises s(k+5) = s(k+3) ^ s(k).
  localparam logic [HASH_W-1:0] COL_TAPS = 5'b01001;
  // Stage k holds s(k) after seeding: s0..s4 = 0,0,0,1,0.
  localparam logic [HASH_W-1:0] COL_SEED = 5'b01000;

  function automatic logic [HASH_W-1:0] bit_reverse(input logic [HASH_W-1:0] v);
    logic [HASH_W-1:0] r;
    for (int i = 0; i < int'(HASH_W); i++) r[i] = v[HASH_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/toeplitz_col_gen.sv
module toeplitz_col_gen #(
  parameter int unsigned           W    = 5,
  parameter logic [W-1:0]          TAPS = 5'b01001,
  parameter logic [W-1:0]          SEED = 5'b01000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] col_o
);
  logic [W-1:0] col_q;
  logic         fb;

  assign fb = ^(col_q & TAPS);

  always_ff @(posedge clk) begin
    if (rst || load_i) col_q <= SEED;
    else if (step_i)   col_q <= {fb, col_q[W-1:1]};
  end

  assign col_o = col_q;
endmodule

// File: rtl/toeplitz_fold_acc.sv
module toeplitz_fold_acc #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         fold_i,
  input  logic [W-1:0] col_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] acc_next_o
);
  logic [W-1:0] acc_q;

  // Next value including the bit being accepted now.
  assign acc_next_o = fold_i ? (acc_q ^ col_i) : acc_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) acc_q <= '0;
    else              acc_q <= acc_next_o;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/toeplitz_msg_ctrl.sv
module toeplitz_msg_ctrl #(
  parameter int unsigned MSG_LEN = 9,
  localparam int unsigned CNT_W  = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic vld_i,
  input  logic last_i,
  output logic take_o,
  output logic finish_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             open_q;

  assign take_o   = vld_i && open_q && !start_i;
  assign finish_o = take_o && (last_i || (cnt_q == CNT_W'(MSG_LEN-1)));

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      cnt_q  <= '0;
      open_q <= 1'b1;
    end else if (finish_o) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else if (take_o) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/toeplitz_hash.sv
module toeplitz_hash
  import toeplitz_pkg::*;
#(
  parameter int unsigned           HW   = HASH_W,
  parameter int unsigned           ML   = MSG_LEN,
  parameter logic [HW-1:0]         TAPS = COL_TAPS,
  parameter logic [HW-1:0]         SEED = COL_SEED
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          bit_vld_i,
  input  logic          bit_i,
  input  logic          last_i,
  output logic [HW-1:0] hash_o,
  output logic          done_o
);
  logic          take, finish;
  logic [HW-1:0] col, acc, acc_next, rev;

  toeplitz_msg_ctrl #(.MSG_LEN(ML)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .vld_i(bit_vld_i),
    .last_i(last_i), .take_o(take), .finish_o(finish)
  );

  toeplitz_col_gen #(.W(HW), .TAPS(TAPS), .SEED(SEED)) u_col (
    .clk(clk), .rst(rst), .load_i(start_i), .step_i(take), .col_o(col)
  );

  toeplitz_fold_acc #(.W(HW)) u_acc (
    .clk(clk), .rst(rst), .clr_i(start_i), .fold_i(take && bit_i),
    .col_i(col), .acc_o(acc), .acc_next_o(acc_next)
  );

  // Accumulator bit t lands on output bit HW-1-t.
  for (genvar t = 0; t < int'(HW); t++) begin : g_rev
    assign rev[HW-1-t] = acc_next[t];
  end

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      hash_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish;
      if (finish) hash_o <= rev;
    end
  end
endmodule

// File: rtl/toeplitz_hash_chk.sv
module toeplitz_hash_chk #(
  parameter int unsigned HW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          bit_vld_i,
  input logic [HW-1:0] hash_o,
  input logic          done_o
);
  // R1 / R9: a start clears the outputs one cycle later.
  a_r1_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (hash_o == '0) && !done_o);

  // R5: done never lasts two cycles.
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5 / R9: done follows an accepted bit, never a start.
  a_r5_done_after_bit: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(bit_vld_i) && !$past(start_i));

  // R6: without start or completion the hash does not move.
  a_r6_hash_hold: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(hash_o) || done_o);
endmodule

bind toeplitz_hash toeplitz_hash_chk #(.HW(HW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .bit_vld_i(bit_vld_i),
  .hash_o(hash_o), .done_o(done_o)
);

// File: tb/toeplitz_hash_tb_top.sv
module toeplitz_hash_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, last_i = 1'b0;
  logic [4:0] hash_o;
  logic       done_o;
  int         errors = 0;
  int         checks = 0;
  bit         ended  = 1'b0;

  always #5 clk = ~clk;

  toeplitz_hash dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .bit_vld_i(bit_vld_i),
    .bit_i(bit_i), .last_i(last_i), .hash_o(hash_o), .done_o(done_o)
  );

  // Sequence s(k), recurrence s(k+5) = s(k+3) ^ s(k), seed 0,0,0,1,0.
  function automatic bit seq(input int k);
    bit s [0:15];
    s[0]=0; s[1]=0; s[2]=0; s[3]=1; s[4]=0;
    for (int i = 5; i < 16; i++) s[i] = s[i-2] ^ s[i-5];
    return s[k];
  endfunction

  // msg[j] = j-th sent bit; only the first len bits count.
  function automatic logic [4:0] model(input logic [8:0] msg, input int len);
    logic [4:0] h = '0;
    for (int t = 0; t < 5; t++)
      for (int j = 0; j < len; j++)
        if (msg[j]) h[4-t] = h[4-t] ^ seq(j+t);
    return h;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Send one message; optional random idle gaps, early end when len<9.
  task automatic send(input logic [8:0] msg, input int len, input bit gaps, input string req);
    logic [4:0] exp = model(msg, len);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(hash_o == 5'd0 && !done_o, "R1", hash_o, 0);
    for (int j = 0; j < len; j++) begin
      if (gaps) begin
        int n = int'($urandom_range(0, 2));
        for (int g = 0; g < n; g++) begin
          bit_vld_i = 1'b0; bit_i = $urandom_range(0, 1); last_i = $urandom_range(0, 1);
          @(negedge clk);
        end
      end
      bit_vld_i = 1'b1; bit_i = msg[j]; last_i = (j == len-1) && (len < 9);
      @(negedge clk);
      if (j < len-1) chk(!done_o, "R5", done_o, 0);
    end
    bit_vld_i = 1'b0; last_i = 1'b0; bit_i = 1'b0;
    chk(done_o == 1'b1, "R5", done_o, 1);
    chk(hash_o == exp, req, hash_o, exp);
    @(negedge clk);
    chk(!done_o && hash_o == exp, "R5", {done_o, hash_o}, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(hash_o == 5'd0 && !done_o, "R1", hash_o, 0);  // R1 reset state
    rst = 1'b0;

    // R3 directed vector: 000010001 -> 10000
    send(9'b100010000, 9, 1'b0, "R3");
    chk(hash_o == 5'b10000, "R3", hash_o, 5'b10000);

    // R2 one-hot messages pick sequence windows
    for (int j = 0; j < 9; j++) begin
      logic [4:0] w;
      for (int t = 0; t < 5; t++) w[4-t] = seq(j+t);
      send(9'b1 << j, 9, 1'b0, "R2");
      chk(hash_o == w, "R2", hash_o, w);
    end

    // R4 all zeros hash to zero; all ones
    send(9'b0, 9, 1'b0, "R4");
    chk(hash_o == 5'd0, "R4", hash_o, 0);
    send(9'h1FF, 9, 1'b0, "R4");

    // R6 extra bits after completion are ignored
    for (int k = 0; k < 4; k++) begin
      bit_vld_i = 1'b1; bit_i = 1'b1; last_i = k[0];
      @(negedge clk);
      chk(!done_o && hash_o == model(9'h1FF, 9), "R6", hash_o, model(9'h1FF, 9));
    end
    bit_vld_i = 1'b0; last_i = 1'b0;

    // R7 random messages with idle gaps carrying junk bits
    for (int n = 0; n < 20; n++) send(9'($urandom), 9, 1'b1, "R7");

    // R8 early end by last flag
    send(9'b000000001, 1, 1'b0, "R8");
    for (int n = 0; n < 10; n++) send(9'($urandom), int'($urandom_range(1, 8)), 1'b1, "R8");

    // R3 linearity: hash(a^b) = hash(a)^hash(b) with random pairs
    for (int n = 0; n < 10; n++) begin
      logic [8:0] a = 9'($urandom), b = 9'($urandom);
      send(a ^ b, 9, 1'b0, "R3");
      chk(hash_o == (model(a, 9) ^ model(b, 9)), "R3", hash_o, model(a, 9) ^ model(b, 9));
    end

    // R9 start together with a valid 1 bit: bit discarded
    @(negedge clk); start_i = 1'b1; bit_vld_i = 1'b1; bit_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int j = 0; j < 9; j++) begin
      bit_i = (j == 8); @(negedge clk);
    end
    bit_vld_i = 1'b0; bit_i = 1'b0;
    chk(done_o && hash_o == model(9'b100000000, 9), "R9", hash_o, model(9'b100000000, 9));
    @(negedge clk);

    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule